// File: doc/BRIEF.md
# Virtual Interrupt Interface Control Register

This block holds the 32-bit control word that describes how a guest sees its virtual interrupt CPU interface. A hypervisor saves and restores the whole word through a privileged port. Every request on that port carries the requester's exception level and the trap-control inputs. A permission gate turns each request into exactly one of three outcomes: success, undefined, or a trap to level 2.

A guest-side port reads and writes narrow views of the same storage: the priority mask, the two binary points, a control view (EOI mode, common binary point, FIQ routing, acknowledge control) and the two group enables. The two binary points are coupled. While the common-binary-point bit is set, the group-1 view reads back a value derived from group 0, and writes to it are dropped.

Decoded outputs give the mask, the effective binary point for each group and the EOI behaviour. A small combinational stage decides whether an offered pending interrupt is signalled, and on which line, and which ID an acknowledge would return.

Top module: `vintf_ctl_reg`

## Requirements
- R1: Writable bits are 31:18, 9 and 4:0. The fields are: mask 31:24, group-0 binary point 23:21, group-1 binary point 20:18, EOI mode 9, common binary point 4, FIQ route 3, acknowledge control 2, group-1 enable 1, group-0 enable 0. All other bits read as zero and ignore writes.
- R2: After reset every field is zero.
- R3: A privileged request from level 0 responds UNDEF. A request from level 1 responds TRAP when `priv_el2_en` and `priv_trap_ctl` are both 1, and UNDEF otherwise.
- R4: A request from level 2 responds OK only when `priv_sre_el2` is 1, and a request from level 3 only when `priv_sre_el3` is 1. Otherwise the response is UNDEF.
- R5: The response is a one-cycle strobe in the cycle after the request. `rsp_code` is one-hot: bit 2 means OK, bit 1 means UNDEF, bit 0 means TRAP. `rsp_syndrome` is 0x03 on TRAP and zero otherwise. A request that is not OK leaves the register unchanged. An OK read returns the word as it stood before that edge.
- R6: Guest views selected by `g_sel` are read combinationally. Writes take effect at the clock edge. The views are: 0 mask (8 bits); 1 group-0 binary point (bits 2:0); 2 group-1 binary point (bits 2:0); 3 control with bit 0 common binary point, bit 1 EOI mode, bit 2 FIQ route and bit 3 acknowledge control; 4 group-0 enable (bit 0); 5 group-1 enable (bit 0).
- R7: While common binary point is 1, a guest read of view 2 returns the group-0 binary point plus one, saturated at 7, and guest writes to view 2 are ignored.
- R8: `grp0_bp` always equals the group-0 binary point. `grp1_bp_eff` equals the group-0 binary point when common binary point is 1, and the group-1 binary point otherwise.
- R9: A pending interrupt is signalled only when its priority is numerically below the mask and the enable for its group is set.
- R10: A signalled group-0 interrupt appears on `sig_fiq` when FIQ route is 1 and on `sig_irq` when it is 0. A signalled group-1 interrupt always appears on `sig_irq`.
- R11: `ack_id` is 1022 when the pending interrupt is group 1 and acknowledge control is 0. In all other cases it is `pend_id`.
- R12: `eoi_split` equals the EOI mode bit. A 1 means end-of-interrupt only drops priority and deactivation is a separate write.
- R13: When an OK privileged write and a guest write land on the same edge, the privileged word wins for every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_req | input | 1 | Privileged access request |
| priv_wr | input | 1 | 1 write, 0 read |
| priv_el | input | 2 | Requesting exception level |
| priv_el2_en | input | 1 | Level 2 is enabled |
| priv_trap_ctl | input | 1 | Trap-control bit for level-1 accesses |
| priv_sre_el2 | input | 1 | System-register enable at level 2 |
| priv_sre_el3 | input | 1 | System-register enable at level 3 |
| priv_wdata | input | 32 | Privileged write word |
| priv_rdata | output | 32 | Read word, valid with an OK read response |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 3 | One-hot {OK, UNDEF, TRAP} |
| rsp_syndrome | output | 8 | Trap syndrome |
| g_sel | input | 3 | Guest view select |
| g_wr | input | 1 | Guest write enable |
| g_wdata | input | 8 | Guest write data |
| g_rdata | output | 8 | Guest read data |
| pend_valid | input | 1 | A pending interrupt is offered |
| pend_prio | input | 8 | Its priority |
| pend_grp | input | 1 | Its group |
| pend_id | input | 10 | Its interrupt ID |
| sig_irq | output | 1 | Signal on the IRQ line |
| sig_fiq | output | 1 | Signal on the FIQ line |
| ack_id | output | 10 | ID an acknowledge would return |
| prio_mask | output | 8 | Current priority mask |
| grp0_bp | output | 3 | Group-0 binary point |
| grp1_bp_eff | output | 3 | Binary point governing group 1 |
| eoi_split | output | 1 | EOI only drops priority |

## Verification
On every cycle the assertions check four things: the shape of the response strobe, that the syndrome appears only on a trap, that a level-0 request never changes the stored word, and that reserved bits read back as zero. They also check that a signalled interrupt always beats the mask and never drives both lines at once. The bench scenarios cover the rest. These are the coupled binary-point alias, with its saturation and dropped writes, the level-1 trap versus undefined split, and the routing and acknowledge-ID choices across group, enable and control settings. They also cover which side wins when privileged and guest writes collide.

// File: rtl/vintf_pkg.sv
package vintf_pkg;
   localparam int WORD_W = 32;
   localparam logic [WORD_W-1:0] RW_MASK = 32'hFFFC_021F;

   localparam int MASK_LSB = 24;
   localparam int BP0_LSB  = 21;
   localparam int BP1_LSB  = 18;
   localparam int EOI_BIT  = 9;
   localparam int CBP_BIT  = 4;
   localparam int FIQ_BIT  = 3;
   localparam int ACK_BIT  = 2;
   localparam int EN1_BIT  = 1;
   localparam int EN0_BIT  = 0;

   localparam logic [2:0] RSP_OK    = 3'b100;
   localparam logic [2:0] RSP_UNDEF = 3'b010;
   localparam logic [2:0] RSP_TRAP  = 3'b001;

   localparam logic [2:0] VIEW_MASK = 3'd0;
   localparam logic [2:0] VIEW_BP0  = 3'd1;
   localparam logic [2:0] VIEW_BP1  = 3'd2;
   localparam logic [2:0] VIEW_CTL  = 3'd3;
   localparam logic [2:0] VIEW_EN0  = 3'd4;
   localparam logic [2:0] VIEW_EN1  = 3'd5;

   function automatic logic [2:0] bp_sat_inc(input logic [2:0] v);
      return (v == 3'd7) ? 3'd7 : v + 3'd1;
   endfunction
endpackage

// File: rtl/vintf_priv_gate.sv
module vintf_priv_gate
   import vintf_pkg::*;
(
   input  logic [1:0] el,
   input  logic       el2_en,
   input  logic       trap_ctl,
   input  logic       sre_el2,
   input  logic       sre_el3,
   output logic [2:0] code
);
   always_comb begin
      unique case (el)
         2'd0: code = RSP_UNDEF;
         2'd1: code = (el2_en && trap_ctl) ? RSP_TRAP : RSP_UNDEF;
         2'd2: code = sre_el2 ? RSP_OK : RSP_UNDEF;
         default: code = sre_el3 ? RSP_OK : RSP_UNDEF;
      endcase
   end
endmodule

// File: rtl/vintf_guest_port.sv
module vintf_guest_port
   import vintf_pkg::*;
#(
   parameter int SEL_W  = 3,
   parameter int GDAT_W = 8
) (
   input  logic [WORD_W-1:0] word,
   input  logic [SEL_W-1:0]  sel,
   input  logic              wr,
   input  logic [GDAT_W-1:0] wdata,
   output logic [GDAT_W-1:0] rdata,
   output logic [WORD_W-1:0] wr_be,
   output logic [WORD_W-1:0] wr_bits
);
   logic       cbp;
   logic [2:0] bp0;
   logic [2:0] bp1;

   assign cbp = word[CBP_BIT];
   assign bp0 = word[BP0_LSB +: 3];
   assign bp1 = word[BP1_LSB +: 3];

   always_comb begin
      rdata   = '0;
      wr_be   = '0;
      wr_bits = '0;
      unique case (sel)
         VIEW_MASK: begin
            rdata = word[MASK_LSB +: 8];
            wr_be[MASK_LSB +: 8]   = {8{wr}};
            wr_bits[MASK_LSB +: 8] = wdata[7:0];
         end
         VIEW_BP0: begin
            rdata[2:0] = bp0;
            wr_be[BP0_LSB +: 3]   = {3{wr}};
            wr_bits[BP0_LSB +: 3] = wdata[2:0];
         end
         VIEW_BP1: begin
            rdata[2:0] = cbp ? bp_sat_inc(bp0) : bp1;
            wr_be[BP1_LSB +: 3]   = {3{wr && !cbp}};
            wr_bits[BP1_LSB +: 3] = wdata[2:0];
         end
         VIEW_CTL: begin
            rdata[3:0] = {word[ACK_BIT], word[FIQ_BIT], word[EOI_BIT], cbp};
            wr_be[CBP_BIT] = wr;
            wr_be[EOI_BIT] = wr;
            wr_be[FIQ_BIT] = wr;
            wr_be[ACK_BIT] = wr;
            wr_bits[CBP_BIT] = wdata[0];
            wr_bits[EOI_BIT] = wdata[1];
            wr_bits[FIQ_BIT] = wdata[2];
            wr_bits[ACK_BIT] = wdata[3];
         end
         VIEW_EN0: begin
            rdata[0] = word[EN0_BIT];
            wr_be[EN0_BIT]   = wr;
            wr_bits[EN0_BIT] = wdata[0];
         end
         VIEW_EN1: begin
            rdata[0] = word[EN1_BIT];
            wr_be[EN1_BIT]   = wr;
            wr_bits[EN1_BIT] = wdata[0];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/vintf_sig_dec.sv
module vintf_sig_dec #(
   parameter int PRIO_W = 8,
   parameter int ID_W   = 10
) (
   input  logic [PRIO_W-1:0] mask,
   input  logic              en0,
   input  logic              en1,
   input  logic              fiq_route,
   input  logic              ack_ctl,
   input  logic              pend_valid,
   input  logic [PRIO_W-1:0] pend_prio,
   input  logic              pend_grp,
   input  logic [ID_W-1:0]   pend_id,
   output logic              sig_irq,
   output logic              sig_fiq,
   output logic [ID_W-1:0]   ack_id
);
   localparam logic [ID_W-1:0] SPURIOUS_ID = ID_W'(1022);

   logic deliver;

   assign deliver = pend_valid && (pend_prio < mask) && (pend_grp ? en1 : en0);
   assign sig_fiq = deliver && !pend_grp && fiq_route;
   assign sig_irq = deliver && !sig_fiq;
   assign ack_id  = (pend_grp && !ack_ctl) ? SPURIOUS_ID : pend_id;
endmodule

// File: rtl/vintf_ctl_reg.sv
module vintf_ctl_reg
   import vintf_pkg::*;
#(
   parameter int SEL_W     = 3,
   parameter int GDAT_W    = 8,
   parameter int PRIO_W    = 8,
   parameter int ID_W      = 10,
   parameter int SYN_W     = 8,
   parameter int TRAP_CODE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              priv_req,
   input  logic              priv_wr,
   input  logic [1:0]        priv_el,
   input  logic              priv_el2_en,
   input  logic              priv_trap_ctl,
   input  logic              priv_sre_el2,
   input  logic              priv_sre_el3,
   input  logic [WORD_W-1:0] priv_wdata,
   output logic [WORD_W-1:0] priv_rdata,
   output logic              rsp_valid,
   output logic [2:0]        rsp_code,
   output logic [SYN_W-1:0]  rsp_syndrome,
   input  logic [SEL_W-1:0]  g_sel,
   input  logic              g_wr,
   input  logic [GDAT_W-1:0] g_wdata,
   output logic [GDAT_W-1:0] g_rdata,
   input  logic              pend_valid,
   input  logic [PRIO_W-1:0] pend_prio,
   input  logic              pend_grp,
   input  logic [ID_W-1:0]   pend_id,
   output logic              sig_irq,
   output logic              sig_fiq,
   output logic [ID_W-1:0]   ack_id,
   output logic [PRIO_W-1:0] prio_mask,
   output logic [2:0]        grp0_bp,
   output logic [2:0]        grp1_bp_eff,
   output logic              eoi_split
);
   localparam logic [SYN_W-1:0] TRAP_SYN = SYN_W'(TRAP_CODE);

   initial begin
      assert (PRIO_W == 8) else $fatal(1, "PRIO_W must match the 8-bit mask field");
      assert (GDAT_W >= 8) else $fatal(1, "GDAT_W must hold the mask view");
      assert (ID_W >= 10)  else $fatal(1, "ID_W must hold ID 1022");
      assert (SEL_W >= 3)  else $fatal(1, "SEL_W must address six views");
      assert (TRAP_CODE < (1 << SYN_W)) else $fatal(1, "TRAP_CODE exceeds SYN_W");
   end

   logic [WORD_W-1:0] vmcr_q;
   logic [WORD_W-1:0] vmcr_d;
   logic [WORD_W-1:0] g_be;
   logic [WORD_W-1:0] g_bits;
   logic [2:0]        gate_code;
   logic              priv_ok;
   logic              priv_we;

   vintf_priv_gate u_gate (
      .el       (priv_el),
      .el2_en   (priv_el2_en),
      .trap_ctl (priv_trap_ctl),
      .sre_el2  (priv_sre_el2),
      .sre_el3  (priv_sre_el3),
      .code     (gate_code)
   );

   assign priv_ok = priv_req && (gate_code == RSP_OK);
   assign priv_we = priv_ok && priv_wr;

   vintf_guest_port #(.SEL_W(SEL_W), .GDAT_W(GDAT_W)) u_guest (
      .word    (vmcr_q),
      .sel     (g_sel),
      .wr      (g_wr),
      .wdata   (g_wdata),
      .rdata   (g_rdata),
      .wr_be   (g_be),
      .wr_bits (g_bits)
   );

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      if (RW_MASK[i]) begin : g_rw
         assign vmcr_d[i] = priv_we  ? priv_wdata[i] :
                            g_be[i]  ? g_bits[i]     : vmcr_q[i];
      end else begin : g_res0
         assign vmcr_d[i] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vmcr_q       <= '0;
         rsp_valid    <= 1'b0;
         rsp_code     <= '0;
         rsp_syndrome <= '0;
         priv_rdata   <= '0;
      end else begin
         vmcr_q       <= vmcr_d;
         rsp_valid    <= priv_req;
         rsp_code     <= priv_req ? gate_code : 3'b000;
         rsp_syndrome <= (priv_req && gate_code == RSP_TRAP) ? TRAP_SYN : '0;
         priv_rdata   <= (priv_ok && !priv_wr) ? vmcr_q : '0;
      end
   end

   assign prio_mask   = vmcr_q[MASK_LSB +: PRIO_W];
   assign grp0_bp     = vmcr_q[BP0_LSB +: 3];
   assign grp1_bp_eff = vmcr_q[CBP_BIT] ? vmcr_q[BP0_LSB +: 3] : vmcr_q[BP1_LSB +: 3];
   assign eoi_split   = vmcr_q[EOI_BIT];

   vintf_sig_dec #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_sig (
      .mask       (prio_mask),
      .en0        (vmcr_q[EN0_BIT]),
      .en1        (vmcr_q[EN1_BIT]),
      .fiq_route  (vmcr_q[FIQ_BIT]),
      .ack_ctl    (vmcr_q[ACK_BIT]),
      .pend_valid (pend_valid),
      .pend_prio  (pend_prio),
      .pend_grp   (pend_grp),
      .pend_id    (pend_id),
      .sig_irq    (sig_irq),
      .sig_fiq    (sig_fiq),
      .ack_id     (ack_id)
   );
endmodule

// File: rtl/vintf_ctl_chk.sv
module vintf_ctl_chk
   import vintf_pkg::*;
#(
   parameter int PRIO_W = 8,
   parameter int SYN_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              priv_req,
   input logic [1:0]        priv_el,
   input logic              g_wr,
   input logic              rsp_valid,
   input logic [2:0]        rsp_code,
   input logic [SYN_W-1:0]  rsp_syndrome,
   input logic [WORD_W-1:0] priv_rdata,
   input logic [WORD_W-1:0] vmcr_q,
   input logic [PRIO_W-1:0] pend_prio,
   input logic [PRIO_W-1:0] prio_mask,
   input logic              sig_irq,
   input logic              sig_fiq
);
   p_resv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ((priv_rdata & ~RW_MASK) == '0));

   p_el0_undef_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_req && priv_el == 2'd0) |=> (rsp_valid && rsp_code == RSP_UNDEF));

   p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones(rsp_code) == 1));

   p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_code == 3'b000 && rsp_syndrome == '0));

   p_syn_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code != RSP_TRAP) |-> (rsp_syndrome == '0));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_req && priv_el == 2'd0 && !g_wr) |=> $stable(vmcr_q));

   p_below_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_irq || sig_fiq) |-> (pend_prio < prio_mask));

   p_one_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(sig_irq && sig_fiq));
endmodule

bind vintf_ctl_reg vintf_ctl_chk #(.PRIO_W(PRIO_W), .SYN_W(SYN_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .priv_req     (priv_req),
   .priv_el      (priv_el),
   .g_wr         (g_wr),
   .rsp_valid    (rsp_valid),
   .rsp_code     (rsp_code),
   .rsp_syndrome (rsp_syndrome),
   .priv_rdata   (priv_rdata),
   .vmcr_q       (vmcr_q),
   .pend_prio    (pend_prio),
   .prio_mask    (prio_mask),
   .sig_irq      (sig_irq),
   .sig_fiq      (sig_fiq)
);

// File: tb/vintf_ctl_reg_test.sv
module vintf_ctl_reg_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        priv_req = 1'b0, priv_wr = 1'b0;
   logic [1:0]  priv_el = 2'd0;
   logic        priv_el2_en = 1'b0, priv_trap_ctl = 1'b0;
   logic        priv_sre_el2 = 1'b0, priv_sre_el3 = 1'b0;
   logic [31:0] priv_wdata = '0;
   logic [31:0] priv_rdata;
   logic        rsp_valid;
   logic [2:0]  rsp_code;
   logic [7:0]  rsp_syndrome;
   logic [2:0]  g_sel = 3'd0;
   logic        g_wr = 1'b0;
   logic [7:0]  g_wdata = '0;
   logic [7:0]  g_rdata;
   logic        pend_valid = 1'b0;
   logic [7:0]  pend_prio = '0;
   logic        pend_grp = 1'b0;
   logic [9:0]  pend_id = '0;
   logic        sig_irq, sig_fiq;
   logic [9:0]  ack_id;
   logic [7:0]  prio_mask;
   logic [2:0]  grp0_bp, grp1_bp_eff;
   logic        eoi_split;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vintf_ctl_reg uut (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic priv_acc(input logic [1:0] el, input logic wr, input logic [31:0] wd,
                           input logic e2en, input logic trap, input logic sre2, input logic sre3,
                           output logic [2:0] code, output logic [7:0] syn, output logic [31:0] rd);
      @(negedge clk);
      priv_req = 1'b1; priv_wr = wr; priv_el = el; priv_wdata = wd;
      priv_el2_en = e2en; priv_trap_ctl = trap; priv_sre_el2 = sre2; priv_sre_el3 = sre3;
      @(negedge clk);
      priv_req = 1'b0; priv_wr = 1'b0;
      check("R5 strobe", {31'd0, rsp_valid}, 32'd1);
      code = rsp_code; syn = rsp_syndrome; rd = priv_rdata;
   endtask

   task automatic el2_read(output logic [31:0] rd);
      logic [2:0] c; logic [7:0] s;
      priv_acc(2'd2, 1'b0, '0, 1'b1, 1'b0, 1'b1, 1'b0, c, s, rd);
   endtask

   task automatic el2_write(input logic [31:0] wd);
      logic [2:0] c; logic [7:0] s; logic [31:0] rd;
      priv_acc(2'd2, 1'b1, wd, 1'b1, 1'b0, 1'b1, 1'b0, c, s, rd);
   endtask

   task automatic g_write(input logic [2:0] sel, input logic [7:0] d);
      @(negedge clk);
      g_sel = sel; g_wr = 1'b1; g_wdata = d;
      @(negedge clk);
      g_wr = 1'b0;
   endtask

   task automatic g_read(input logic [2:0] sel, output logic [7:0] d);
      g_sel = sel;
      #1;
      d = g_rdata;
   endtask

   task automatic offer(input logic v, input logic [7:0] pr, input logic gp, input logic [9:0] id);
      pend_valid = v; pend_prio = pr; pend_grp = gp; pend_id = id;
      #1;
   endtask

   task automatic t_reset;
      logic [31:0] rd;
      check("R2 rsp idle", {29'd0, rsp_code}, 32'd0);
      check("R2 mask", {24'd0, prio_mask}, 32'd0);
      el2_read(rd);
      check("R2 word", rd, 32'd0);
   endtask

   task automatic t_perm;
      logic [2:0] c; logic [7:0] s; logic [31:0] rd;
      priv_acc(2'd0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1, c, s, rd);
      check("R3 el0 undef", {29'd0, c}, 32'b010);
      check("R5 no syn on undef", {24'd0, s}, 32'd0);
      priv_acc(2'd1, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1, c, s, rd);
      check("R3 el1 trap", {29'd0, c}, 32'b001);
      check("R5 trap syndrome", {24'd0, s}, 32'h03);
      priv_acc(2'd1, 1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b1, c, s, rd);
      check("R3 el1 no el2 undef", {29'd0, c}, 32'b010);
      priv_acc(2'd1, 1'b0, '0, 1'b1, 1'b0, 1'b1, 1'b1, c, s, rd);
      check("R3 el1 no trap undef", {29'd0, c}, 32'b010);
      priv_acc(2'd2, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b1, c, s, rd);
      check("R4 el2 sre off", {29'd0, c}, 32'b010);
      priv_acc(2'd3, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0, c, s, rd);
      check("R4 el3 sre off", {29'd0, c}, 32'b010);
      priv_acc(2'd3, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, c, s, rd);
      check("R4 el3 ok", {29'd0, c}, 32'b100);
      check("R5 failed writes kept word", rd, 32'd0);
   endtask

   task automatic t_layout;
      logic [31:0] rd;
      el2_write(32'hFFFF_FFFF);
      el2_read(rd);
      check("R1 reserved read zero", rd, 32'hFFFC_021F);
      el2_write(32'hA5A8_0219);
      el2_read(rd);
      check("R1 readback", rd, 32'hA5A8_0219);
      check("R1 mask field", {24'd0, prio_mask}, 32'hA5);
      check("R8 grp0 bp", {29'd0, grp0_bp}, 32'd5);
      check("R8 grp1 follows grp0", {29'd0, grp1_bp_eff}, 32'd5);
      check("R12 split", {31'd0, eoi_split}, 32'd1);
   endtask

   task automatic t_guest;
      logic [7:0] d; logic [31:0] rd;
      g_read(3'd2, d);
      check("R7 alias plus one", {24'd0, d}, 32'd6);
      g_write(3'd2, 8'd1);
      el2_read(rd);
      check("R7 write dropped", {29'd0, rd[20:18]}, 32'd2);
      g_write(3'd1, 8'd7);
      g_read(3'd2, d);
      check("R7 saturate", {24'd0, d}, 32'd7);
      g_write(3'd3, 8'h06);
      g_read(3'd2, d);
      check("R7 own bp when off", {24'd0, d}, 32'd2);
      check("R8 grp1 own", {29'd0, grp1_bp_eff}, 32'd2);
      g_write(3'd2, 8'd4);
      g_read(3'd2, d);
      check("R6 bp1 write", {24'd0, d}, 32'd4);
      g_write(3'd0, 8'h40);
      g_read(3'd0, d);
      check("R6 mask view", {24'd0, d}, 32'h40);
      g_read(3'd3, d);
      check("R6 ctl view", {24'd0, d}, 32'h06);
      g_read(3'd4, d);
      check("R6 en0 view", {24'd0, d}, 32'd1);
      el2_read(rd);
      check("R6 word after guest", rd, 32'h40F0_0209);
   endtask

   task automatic t_signal;
      offer(1'b1, 8'h3F, 1'b0, 10'd5);
      check("R10 grp0 fiq", {30'd0, sig_irq, sig_fiq}, 32'b01);
      offer(1'b1, 8'h40, 1'b0, 10'd5);
      check("R9 equal blocked", {30'd0, sig_irq, sig_fiq}, 32'b00);
      offer(1'b1, 8'h10, 1'b1, 10'd37);
      check("R9 grp1 disabled", {30'd0, sig_irq, sig_fiq}, 32'b00);
      check("R11 spurious id", {22'd0, ack_id}, 32'd1022);
      g_write(3'd5, 8'd1);
      #1;
      check("R10 grp1 irq", {30'd0, sig_irq, sig_fiq}, 32'b10);
      g_write(3'd3, 8'h0A);
      #1;
      check("R11 real id", {22'd0, ack_id}, 32'd37);
      offer(1'b1, 8'h3F, 1'b0, 10'd9);
      check("R10 grp0 irq", {30'd0, sig_irq, sig_fiq}, 32'b10);
      g_write(3'd4, 8'd0);
      #1;
      check("R9 grp0 disabled", {30'd0, sig_irq, sig_fiq}, 32'b00);
      offer(1'b0, 8'h00, 1'b0, 10'd0);
   endtask

   task automatic t_collide;
      logic [2:0] c; logic [7:0] s; logic [31:0] rd;
      @(negedge clk);
      g_sel = 3'd0; g_wr = 1'b1; g_wdata = 8'hFF;
      priv_acc(2'd3, 1'b1, 32'h0000_0003, 1'b0, 1'b0, 1'b0, 1'b1, c, s, rd);
      g_wr = 1'b0;
      el2_read(rd);
      check("R13 privileged wins", rd, 32'h0000_0003);
      check("R12 no split", {31'd0, eoi_split}, 32'd0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_perm();
      t_layout();
      t_guest();
      t_signal();
      t_collide();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule